// File: doc/BRIEF.md
# Single-Channel DMA Mover with Suspend and Drain

This block moves a configured number of data items from a source port to a destination port. The items pass through a small internal FIFO, and the transfer is organised as a number of equal-length blocks. Software starts the channel by writing the enable bit of a two-bit control register. At that moment the channel captures the source start address, the destination start address, the block length, the block count and the source-reload mode. The channel then issues reads on a valid/ready source port and writes on a valid/ready destination port. After the final item has been written, hardware clears the enable bit by itself.

A transfer can be stopped early without losing data. Software sets the suspend bit, and the channel stops issuing source reads. It keeps writing whatever the FIFO already holds until the FIFO is empty. A status bit shows when the FIFO is empty. From that point software may either clear enable or clear suspend to carry on. If it carries on, reading resumes at the next address that has not been fetched. In reload mode the source address goes back to its start value at each block boundary, while the destination address keeps counting. One-cycle pulses mark the end of each block and the end of the whole transfer.

Top module: `dmach_top`

## Requirements
- R1: A register write with enable 1 while the channel is off, with nonzero length and count, sets `stat_en` in the next cycle. The first source read then uses the captured source start address.
- R2: In the cycle after the handshake of the final item (last item of the last block) on the destination port, `stat_en` reads 0 without any software write.
- R3: While `stat_susp` is 1, `src_rd_valid` stays 0, so no item enters the FIFO.
- R4: While enabled and suspended, the channel keeps presenting FIFO items on the destination port until the FIFO is empty.
- R5: `stat_fifo_empty` is 1 exactly when every item accepted from the source has been written out or discarded, and it is 1 after reset.
- R6: Destination item k carries the data read for source item k. No item is duplicated or skipped, and this includes transfers that are suspended and then resumed.
- R7: A register write with enable 0 while enabled turns the channel off in the next cycle. It discards the FIFO contents, so `stat_fifo_empty` reads 1, and neither port shows valid afterwards.
- R8: With `cfg_src_reload` = 1, the source address for item k is start + (k mod length). The destination address is always start + k.
- R9: With `cfg_src_reload` = 0, the source address for item k is start + k.
- R10: `irq_block` pulses for one cycle after the last item of each block is written, which gives count pulses per transfer. `irq_xfer` pulses once, in the same cycle as the final `irq_block`.
- R11: The FIFO holds at most 8 items. With 8 items outstanding, `src_rd_valid` is 0 until the destination accepts one.
- R12: An enable write with block length 0 or block count 0 leaves the channel off.
- R13: Changing the `cfg_*` inputs while a transfer runs has no effect on its addresses, data or item total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wen | input | 1 | Enable value written |
| reg_wsusp | input | 1 | Suspend value written |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_blk_len | input | LEN_W | Items per block |
| cfg_blk_cnt | input | CNT_W | Blocks per transfer |
| cfg_src_reload | input | 1 | 1: source address restarts each block |
| stat_en | output | 1 | Enable bit as read back |
| stat_susp | output | 1 | Suspend bit as read back |
| stat_fifo_empty | output | 1 | FIFO holds no item |
| src_rd_valid | output | 1 | Source read request |
| src_rd_addr | output | ADDR_W | Source read address |
| src_rd_ready | input | 1 | Source returns data this cycle |
| src_rd_data | input | DATA_W | Source read data |
| dst_wr_valid | output | 1 | Destination write request |
| dst_wr_addr | output | ADDR_W | Destination write address |
| dst_wr_data | output | DATA_W | Destination write data |
| dst_wr_ready | input | 1 | Destination accepts write |
| irq_block | output | 1 | Block-complete pulse |
| irq_xfer | output | 1 | Transfer-complete pulse |

## Verification
A control write takes effect in the cycle after its clock edge. The status bits, the valid outputs and the FIFO flush are all visible by then, so the bench checks them one cycle after the write strobe. `irq_block`, `irq_xfer` and the hardware clearing of `stat_en` appear one cycle after the destination handshake that caused them. The bench therefore carries a pending flag from one sample to the next and compares it there. Each handshake is sampled a few nanoseconds after the falling edge, once the ready inputs for that cycle are set, and it is compared against the address and data sequence that the bench computes for item k.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    localparam int DMACH_FIFO_DEPTH = 8;

    typedef struct packed {
        logic en;
        logic susp;
    } dmach_ctl_t;
endpackage

// File: rtl/dmach_fifo.sv
module dmach_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [PTR_W-1:0] wp_inc, rp_inc;
    logic [WIDTH-1:0] mem [DEPTH];

    // pointer wrap: free-running for power-of-two depth, compare otherwise
    generate
        if (DEPTH == (1 << PTR_W)) begin : g_pow2
            assign wp_inc = q.wp + PTR_W'(1);
            assign rp_inc = q.rp + PTR_W'(1);
        end else begin : g_cmp
            assign wp_inc = (q.wp == LAST) ? '0 : q.wp + PTR_W'(1);
            assign rp_inc = (q.rp == LAST) ? '0 : q.rp + PTR_W'(1);
        end
    endgenerate

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push) d.wp = wp_inc;
            if (pop)  d.rp = rp_inc;
            case ({push, pop})
                2'b10:   d.cnt = q.cnt + CNT_W'(1);
                2'b01:   d.cnt = q.cnt - CNT_W'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign full  = (q.cnt == CNT_W'(DEPTH));
    assign empty = (q.cnt == '0);
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
    import dmach_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  dmach_ctl_t reg_wdata,
    input  logic       cfg_ok,
    input  logic       xfer_done,
    output dmach_ctl_t ctl,
    output logic       start,
    output logic       flush
);
    dmach_ctl_t q, d;

    assign start = reg_wr && reg_wdata.en && !q.en && cfg_ok;
    assign flush = reg_wr && !reg_wdata.en && q.en;

    always_comb begin
        d = q;
        if (xfer_done) d.en = 1'b0;
        if (reg_wr) begin
            d.susp = reg_wdata.susp;
            d.en   = start || (reg_wdata.en && q.en && !xfer_done);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl = q;
endmodule

// File: rtl/dmach_src.sv
module dmach_src #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  logic              cfg_reload,
    input  logic              active,
    input  logic              fifo_full,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_fire
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  item;
        logic [CNT_W-1:0]  blk;
        logic              reload;
    } src_st_t;

    src_st_t q, d;
    logic    blk_last;

    assign rd_valid = active && !fifo_full && (q.blk != q.cnt);
    assign rd_fire  = rd_valid && rd_ready;
    assign blk_last = (q.item == q.len - LEN_W'(1));

    always_comb begin
        d = q;
        if (start) begin
            d.base   = cfg_addr;
            d.addr   = cfg_addr;
            d.len    = cfg_len;
            d.cnt    = cfg_cnt;
            d.reload = cfg_reload;
            d.item   = '0;
            d.blk    = '0;
        end else if (rd_fire) begin
            if (blk_last) begin
                d.item = '0;
                d.blk  = q.blk + CNT_W'(1);
                d.addr = q.reload ? q.base : q.addr + ADDR_W'(1);
            end else begin
                d.item = q.item + LEN_W'(1);
                d.addr = q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr = q.addr;
endmodule

// File: rtl/dmach_dst.sv
module dmach_dst #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  logic              enabled,
    input  logic              fifo_empty,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_fire,
    output logic              xfer_done,
    output logic              irq_block,
    output logic              irq_xfer
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  item;
        logic [CNT_W-1:0]  blk;
        logic              irq_blk;
        logic              irq_all;
    } dst_st_t;

    dst_st_t q, d;
    logic    item_last, blk_final;

    assign wr_valid  = enabled && !fifo_empty;
    assign wr_fire   = wr_valid && wr_ready;
    assign item_last = (q.item == q.len - LEN_W'(1));
    assign blk_final = (q.blk == q.cnt - CNT_W'(1));
    assign xfer_done = wr_fire && item_last && blk_final;

    always_comb begin
        d         = q;
        d.irq_blk = wr_fire && item_last;
        d.irq_all = xfer_done;
        if (start) begin
            d.addr = cfg_addr;
            d.len  = cfg_len;
            d.cnt  = cfg_cnt;
            d.item = '0;
            d.blk  = '0;
        end else if (wr_fire) begin
            d.addr = q.addr + ADDR_W'(1);
            if (item_last) begin
                d.item = '0;
                d.blk  = q.blk + CNT_W'(1);
            end else begin
                d.item = q.item + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_addr   = q.addr;
    assign irq_block = q.irq_blk;
    assign irq_xfer  = q.irq_all;
endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int LEN_W      = 8,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = DMACH_FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wen,
    input  logic              reg_wsusp,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [LEN_W-1:0]  cfg_blk_len,
    input  logic [CNT_W-1:0]  cfg_blk_cnt,
    input  logic              cfg_src_reload,
    output logic              stat_en,
    output logic              stat_susp,
    output logic              stat_fifo_empty,
    output logic              src_rd_valid,
    output logic [ADDR_W-1:0] src_rd_addr,
    input  logic              src_rd_ready,
    input  logic [DATA_W-1:0] src_rd_data,
    output logic              dst_wr_valid,
    output logic [ADDR_W-1:0] dst_wr_addr,
    output logic [DATA_W-1:0] dst_wr_data,
    input  logic              dst_wr_ready,
    output logic              irq_block,
    output logic              irq_xfer
);
    dmach_ctl_t wdata, ctl;
    logic start, flush, cfg_ok, xfer_done;
    logic push, pop, fifo_full, fifo_empty;

    assign wdata.en   = reg_wen;
    assign wdata.susp = reg_wsusp;
    assign cfg_ok     = (cfg_blk_len != '0) && (cfg_blk_cnt != '0);

    dmach_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (wdata),
        .cfg_ok    (cfg_ok),
        .xfer_done (xfer_done),
        .ctl       (ctl),
        .start     (start),
        .flush     (flush)
    );

    dmach_src #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_addr   (cfg_src_addr),
        .cfg_len    (cfg_blk_len),
        .cfg_cnt    (cfg_blk_cnt),
        .cfg_reload (cfg_src_reload),
        .active     (ctl.en && !ctl.susp),
        .fifo_full  (fifo_full),
        .rd_ready   (src_rd_ready),
        .rd_valid   (src_rd_valid),
        .rd_addr    (src_rd_addr),
        .rd_fire    (push)
    );

    dmach_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .wdata (src_rd_data),
        .pop   (pop),
        .rdata (dst_wr_data),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    dmach_dst #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_addr   (cfg_dst_addr),
        .cfg_len    (cfg_blk_len),
        .cfg_cnt    (cfg_blk_cnt),
        .enabled    (ctl.en),
        .fifo_empty (fifo_empty),
        .wr_ready   (dst_wr_ready),
        .wr_valid   (dst_wr_valid),
        .wr_addr    (dst_wr_addr),
        .wr_fire    (pop),
        .xfer_done  (xfer_done),
        .irq_block  (irq_block),
        .irq_xfer   (irq_xfer)
    );

    assign stat_en         = ctl.en;
    assign stat_susp       = ctl.susp;
    assign stat_fifo_empty = fifo_empty;
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int FIFO_DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic reg_wen,
    input logic stat_en,
    input logic stat_susp,
    input logic stat_fifo_empty,
    input logic src_rd_valid,
    input logic src_rd_ready,
    input logic dst_wr_valid,
    input logic dst_wr_ready,
    input logic irq_block,
    input logic irq_xfer
);
    int held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          held <= 0;
        else if (reg_wr && !reg_wen && stat_en) held <= 0;
        else held <= held + int'(src_rd_valid && src_rd_ready)
                          - int'(dst_wr_valid && dst_wr_ready);
    end

    a_r3_no_read_when_susp: assert property (@(posedge clk) disable iff (!rst_n)
        stat_susp |-> !src_rd_valid);
    a_r4_drain_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en && !stat_fifo_empty) |-> dst_wr_valid);
    a_r5_empty_matches: assert property (@(posedge clk) disable iff (!rst_n)
        stat_fifo_empty == (held == 0));
    a_r7_flush_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wen && stat_en) |=> (stat_fifo_empty && !stat_en));
    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en |-> (!src_rd_valid && !dst_wr_valid));
    a_r10_xfer_with_block: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer |-> (irq_block && !stat_en));
    a_r10_xfer_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_xfer |=> !irq_xfer);
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        held <= FIFO_DEPTH);
    a_r11_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (held == FIFO_DEPTH) |-> !src_rd_valid);
endmodule

bind dmach_top dmach_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_wr          (reg_wr),
    .reg_wen         (reg_wen),
    .stat_en         (stat_en),
    .stat_susp       (stat_susp),
    .stat_fifo_empty (stat_fifo_empty),
    .src_rd_valid    (src_rd_valid),
    .src_rd_ready    (src_rd_ready),
    .dst_wr_valid    (dst_wr_valid),
    .dst_wr_ready    (dst_wr_ready),
    .irq_block       (irq_block),
    .irq_xfer        (irq_xfer)
);

// File: tb/tb_dmach_top.sv
`timescale 1ns/1ps
module tb_dmach_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_wen = 1'b0, reg_wsusp = 1'b0;
    logic [15:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [7:0]  cfg_blk_len = '0, cfg_blk_cnt = '0;
    logic        cfg_src_reload = 1'b0;
    logic        stat_en, stat_susp, stat_fifo_empty;
    logic        src_rd_valid, src_rd_ready = 1'b0;
    logic [15:0] src_rd_addr, src_rd_data;
    logic        dst_wr_valid, dst_wr_ready = 1'b0;
    logic [15:0] dst_wr_addr, dst_wr_data;
    logic        irq_block, irq_xfer;

    always #5 clk = ~clk;

    function automatic logic [15:0] src_val(logic [15:0] a);
        return (a * 16'd40503) ^ 16'h5A3C;
    endfunction

    assign src_rd_data = src_val(src_rd_addr);

    dmach_top dut (.*);

    int nchk = 0, nfail = 0;
    logic [15:0] e_src, e_dst;
    int  e_len = 1, e_cnt = 1;
    bit  e_rel = 0;
    int  rd_k = 0, wr_k = 0, blk_irqs = 0, xfer_irqs = 0;
    bit  pend_blk = 0, pend_last = 0;
    int  dmode = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_src(int k);
        return e_rel ? e_src + 16'(k % e_len) : e_src + 16'(k);
    endfunction

    // ready drive and handshake monitor
    initial begin
        forever begin
            @(negedge clk);
            src_rd_ready = ($urandom % 4) != 0;
            dst_wr_ready = (dmode == 0) ? (($urandom % 4) != 0) : 1'b0;
            #2;
            if (rst_n) begin
                if (pend_blk || irq_block)
                    chk(irq_block == pend_blk, "R10", "irq_block", int'(irq_block), int'(pend_blk));
                if (pend_last || irq_xfer) begin
                    chk(irq_xfer == pend_last, "R10", "irq_xfer", int'(irq_xfer), int'(pend_last));
                    chk(!stat_en, "R2", "enable self-clear", int'(stat_en), 0);
                end
                if (irq_block) blk_irqs++;
                if (irq_xfer)  xfer_irqs++;
                if (stat_en && (rd_k - wr_k == 8))
                    chk(!src_rd_valid, "R11", "read while 8 held", int'(src_rd_valid), 0);
                if (src_rd_valid && src_rd_ready) begin
                    chk(src_rd_addr == exp_src(rd_k), e_rel ? "R8" : "R9", "source address",
                        int'(src_rd_addr), int'(exp_src(rd_k)));
                    rd_k++;
                end
                if (dst_wr_valid && dst_wr_ready) begin
                    chk(dst_wr_addr == e_dst + 16'(wr_k), "R8", "destination address",
                        int'(dst_wr_addr), int'(e_dst + 16'(wr_k)));
                    chk(dst_wr_data == src_val(exp_src(wr_k)), "R6", "destination data",
                        int'(dst_wr_data), int'(src_val(exp_src(wr_k))));
                    pend_blk  = ((wr_k + 1) % e_len) == 0;
                    pend_last = pend_blk && (wr_k + 1 == e_len * e_cnt);
                    wr_k++;
                end else begin
                    pend_blk  = 0;
                    pend_last = 0;
                end
            end
        end
    end

    task automatic reg_write(bit en, bit susp);
        @(negedge clk);
        reg_wr = 1'b1; reg_wen = en; reg_wsusp = susp;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic start_xfer(logic [15:0] s, logic [15:0] dd, int len, int cnt, bit rel);
        @(negedge clk);
        cfg_src_addr = s; cfg_dst_addr = dd;
        cfg_blk_len = 8'(len); cfg_blk_cnt = 8'(cnt); cfg_src_reload = rel;
        e_src = s; e_dst = dd; e_len = len; e_cnt = cnt; e_rel = rel;
        rd_k = 0; wr_k = 0; blk_irqs = 0; xfer_irqs = 0;
        reg_wr = 1'b1; reg_wen = 1'b1; reg_wsusp = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0;
        // R13: disturb configuration after capture
        cfg_src_addr = s ^ 16'hFFFF; cfg_dst_addr = dd + 16'd77;
        cfg_blk_len = 8'(len + 3); cfg_blk_cnt = 8'(cnt + 1); cfg_src_reload = !rel;
        #1 chk(stat_en == 1'b1, "R1", "enable after write", int'(stat_en), 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (stat_en && n < 5000) begin
            @(negedge clk);
            n++;
        end
        #3;
        chk(!stat_en, "R2", "transfer finished", int'(stat_en), 0);
        chk(wr_k == e_len * e_cnt, "R13", "items written", wr_k, e_len * e_cnt);
        chk(blk_irqs == e_cnt, "R10", "block pulses", blk_irqs, e_cnt);
        chk(xfer_irqs == 1, "R10", "transfer pulses", xfer_irqs, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        #1;
        chk(!stat_en, "R7", "reset enable", int'(stat_en), 0);
        chk(stat_fifo_empty, "R5", "reset empty", int'(stat_fifo_empty), 1);
        chk(!src_rd_valid && !dst_wr_valid, "R7", "reset valids",
            int'(src_rd_valid) + int'(dst_wr_valid), 0);
        chk(!irq_block && !irq_xfer, "R10", "reset irqs", int'(irq_block) + int'(irq_xfer), 0);
        rst_n = 1'b1;

        // directed: contiguous, reload, single-item corners
        start_xfer(16'h0100, 16'h0800, 5, 3, 0); wait_done();
        start_xfer(16'h0200, 16'h0900, 4, 3, 1); wait_done();
        start_xfer(16'hFFFE, 16'hFFFD, 1, 1, 0); wait_done();
        start_xfer(16'h0300, 16'h0A00, 1, 4, 1); wait_done();

        // R12: zero length / zero count ignored
        @(negedge clk);
        cfg_blk_len = 8'd0; cfg_blk_cnt = 8'd3;
        reg_write(1, 0);
        #1 chk(!stat_en && !src_rd_valid, "R12", "zero length start", int'(stat_en), 0);
        cfg_blk_len = 8'd4; cfg_blk_cnt = 8'd0;
        reg_write(1, 0);
        #1 chk(!stat_en && !src_rd_valid, "R12", "zero count start", int'(stat_en), 0);

        // suspend, drain, resume
        dmode = 1;
        start_xfer(16'h1000, 16'h2000, 20, 2, 0);
        repeat (40) @(negedge clk);
        #3;
        chk(rd_k == 8, "R11", "items held with blocked sink", rd_k, 8);
        chk(!stat_fifo_empty, "R5", "empty flag while holding", int'(stat_fifo_empty), 0);
        reg_write(1, 1);
        dmode = 0;
        begin
            int n = 0;
            #3;
            while (!stat_fifo_empty && n < 500) begin
                @(negedge clk); #3; n++;
            end
        end
        chk(stat_fifo_empty, "R5", "empty after drain", int'(stat_fifo_empty), 1);
        chk(wr_k == rd_k, "R4", "drained all read items", wr_k, rd_k);
        chk(rd_k == 8, "R3", "no reads while suspended", rd_k, 8);
        chk(stat_en, "R4", "still enabled while suspended", int'(stat_en), 1);
        repeat (10) @(negedge clk);
        #3 chk(rd_k == 8, "R3", "still no reads", rd_k, 8);
        reg_write(1, 0);
        wait_done();

        // software disable discards data
        dmode = 1;
        start_xfer(16'h3000, 16'h4000, 10, 3, 1);
        repeat (20) @(negedge clk);
        reg_write(0, 0);
        #1;
        chk(!stat_en, "R7", "disabled", int'(stat_en), 0);
        chk(stat_fifo_empty, "R7", "flushed", int'(stat_fifo_empty), 1);
        chk(!src_rd_valid && !dst_wr_valid, "R7", "ports idle",
            int'(src_rd_valid) + int'(dst_wr_valid), 0);
        dmode = 0;
        repeat (10) @(negedge clk);
        #3 chk(wr_k == 0, "R7", "nothing written after disable", wr_k, 0);

        // random transfers
        for (int i = 0; i < 12; i++) begin
            start_xfer(16'($urandom), 16'($urandom), 1 + int'($urandom % 12),
                       1 + int'($urandom % 5), bit'($urandom % 2));
            wait_done();
        end

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule